// File: doc/BRIEF.md
# Three-Phase Half-Bridge Gate Sequencer

This block turns three per-phase logic commands into six gate commands for a three-phase power stage, one high-side and one low-side command per phase. Each phase has a level input that selects which switch should conduct and an enable that releases the phase. Every phase change passes through a both-off gap of a fixed number of clock cycles, so a phase never commands both of its switches at once.

A digital temperature code is compared against a trip level and a lower release level. Crossing the trip level forces all six gates off. The gates stay off until the code has fallen to the release level. The phase inputs and enables are brought into the clock domain by two-flop synchronisers before any decision is made. The temperature code is assumed to come from a sampler that already runs on the same clock.

Top module: `hbg_top`

## Requirements
- R1: With a phase enable low, both gates of that phase are off. A falling enable turns a conducting gate off on the third rising clock edge after the port changes.
- R2: With the enable high and the phase input high, once settled, gate_hi of that phase is 1 and gate_lo is 0.
- R3: With the enable high and the phase input low, once settled, gate_lo of that phase is 1 and gate_hi is 0.
- R4: gate_hi and gate_lo of one phase are never 1 in the same cycle.
- R5: When the phase input changes, the conducting gate turns off on the third rising edge after the port change (two synchroniser stages plus one).
- R6: After a gate turns off, the opposite gate turns on exactly DEAD_CYC cycles later, and no gate turns on with fewer than DEAD_CYC both-off cycles before it.
- R7: If the phase input returns to its old level during the gap, the original gate turns back on DEAD_CYC cycles after it turned off, and the opposite gate never turns on.
- R8: All gates are off while rst_n is low, and for DEAD_CYC cycles after the first rising edge with rst_n high.
- R9: A temp_code of TRIP_CODE or more, unsigned, turns every gate off on the second rising edge after it appears. A code of TRIP_CODE-1 has no effect.
- R10: After a trip, gates stay off while temp_code is above RELEASE_CODE. When the code reaches RELEASE_CODE or less, gates resume on the second rising edge, provided the gap has already elapsed.
- R11: The phases are independent: a change on one phase leaves the gates of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_in | input | NUM_CH | Per-phase level: 1 selects the high side, 0 the low side |
| phase_en | input | NUM_CH | Per-phase enable, active high |
| temp_code | input | TEMP_W | Unsigned temperature code, same clock domain |
| gate_hi | output | NUM_CH | High-side gate command per phase |
| gate_lo | output | NUM_CH | Low-side gate command per phase |

## Verification
The bench builds the block with DEAD_CYC = 6, three phases, an 8-bit temperature code, a trip level of 160 and a release level of 140. The short gap allows the turn-off edge, the last both-off cycle and the turn-on edge to be sampled individually for every transition, including a one-cycle input glitch inside the gap. The two thermal levels are chosen so that the codes one below the trip, inside the hysteresis band and exactly at the release level can each be applied and checked.

// File: rtl/hbg_pkg.sv
// Package: shared types for the half-bridge gate sequencer.
package hbg_pkg;
    // Which switch of a phase is commanded on.
    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_HI  = 2'd1,
        DRV_LO  = 2'd2
    } drv_e;
endpackage

// File: rtl/hbg_sync.sv
// Module: hbg_sync
// Two-flop synchroniser, one chain per bit.
// Assumes: each bit is an independent level, so no bus coherence is needed.
module hbg_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    // Shift the asynchronous levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/hbg_thermal.sv
// Module: hbg_thermal
// Hysteretic over-temperature latch. Sets at or above TRIP_CODE and clears at
// or below RELEASE_CODE.
// Assumes: temp_code is already synchronous to clk; RELEASE_CODE < TRIP_CODE.
module hbg_thermal #(
    parameter int TEMP_W       = 8,
    parameter int TRIP_CODE    = 160,
    parameter int RELEASE_CODE = 140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              fault
);
    localparam logic [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP_CODE);
    localparam logic [TEMP_W-1:0] REL_V  = TEMP_W'(RELEASE_CODE);

    // Set the latch on a hot code and clear it only on a cool one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else if (!fault && temp_code >= TRIP_V) begin
            fault <= 1'b1;
        end else if (fault && temp_code <= REL_V) begin
            fault <= 1'b0;
        end
    end

    AST_TRIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(temp_code) >= TRIP_V) |-> fault); // R9
    AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fault) && $past(temp_code) > REL_V) |-> fault); // R10
    AST_TRIP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(temp_code) <= REL_V) |-> !fault); // R10
endmodule

// File: rtl/hbg_channel.sv
// Module: hbg_channel
// One phase: picks the wanted switch from the synchronised level, enable and
// fault. It drops the conducting switch at once and turns on a switch only
// after DEAD_CYC both-off cycles.
// Assumes: DEAD_CYC >= 2; inputs are already synchronous to clk.
module hbg_channel
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_s,
    input  logic en_s,
    input  logic fault,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int CNT_W = $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEAD_CYC);

    drv_e             want;
    drv_e             drive;
    logic [CNT_W-1:0] gap_cnt;

    // Decide which switch this phase should be conducting.
    always_comb begin
        if (!en_s || fault) want = DRV_OFF;
        else if (in_s)      want = DRV_HI;
        else                want = DRV_LO;
    end

    // Sequence the switches: off at once, on only after the gap has run out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive   <= DRV_OFF;
            gap_cnt <= CNT_LOAD;
        end else if (drive != DRV_OFF) begin
            if (want != drive) begin
                drive   <= DRV_OFF;
                gap_cnt <= CNT_LOAD;
            end
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end else if (want != DRV_OFF) begin
            drive <= want;
        end
    end

    assign gate_hi = (drive == DRV_HI);
    assign gate_lo = (drive == DRV_LO);

    // Count consecutive both-off cycles for the gap check below.
    logic [CNT_W-1:0] off_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                   off_run <= '0;
        else if (gate_hi || gate_lo)  off_run <= '0;
        else if (off_run != CNT_FULL) off_run <= off_run + 1'b1;
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo)); // R4
    AST_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> off_run == CNT_FULL); // R6
    AST_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> off_run == CNT_FULL); // R6
    AST_PROMPT_OFF_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(gate_hi) && $past(!in_s || !en_s || fault)) |-> !gate_hi); // R5
    AST_PROMPT_OFF_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(gate_lo) && $past(in_s || !en_s || fault)) |-> !gate_lo); // R5
    AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en_s)) |-> (!gate_hi && !gate_lo)); // R1
endmodule

// File: rtl/hbg_top.sv
// Module: hbg_top
// Three-phase gate sequencer: synchronises the phase levels and enables,
// runs the thermal latch and one dead-time sequencer per phase.
// Assumes: temp_code is synchronous to clk.
module hbg_top #(
    parameter int NUM_CH       = 3,
    parameter int DEAD_CYC     = 30,
    parameter int TEMP_W       = 8,
    parameter int TRIP_CODE    = 160,
    parameter int RELEASE_CODE = 140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] phase_in,
    input  logic [NUM_CH-1:0] phase_en,
    input  logic [TEMP_W-1:0] temp_code,
    output logic [NUM_CH-1:0] gate_hi,
    output logic [NUM_CH-1:0] gate_lo
);
    localparam int SYNC_W = 2 * NUM_CH;

    logic [SYNC_W-1:0] sync_q;
    logic [NUM_CH-1:0] in_s;
    logic [NUM_CH-1:0] en_s;
    logic              fault;

    hbg_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({phase_en, phase_in}),
        .q_sync  (sync_q)
    );

    assign in_s = sync_q[NUM_CH-1:0];
    assign en_s = sync_q[SYNC_W-1:NUM_CH];

    hbg_thermal #(
        .TEMP_W       (TEMP_W),
        .TRIP_CODE    (TRIP_CODE),
        .RELEASE_CODE (RELEASE_CODE)
    ) u_thermal (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_code (temp_code),
        .fault     (fault)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        hbg_channel #(.DEAD_CYC(DEAD_CYC)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_s    (in_s[ch]),
            .en_s    (en_s[ch]),
            .fault   (fault),
            .gate_hi (gate_hi[ch]),
            .gate_lo (gate_lo[ch])
        );
    end

    AST_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fault)) |-> (gate_hi == '0 && gate_lo == '0)); // R9
endmodule

// File: tb/hbg_top_tb.sv
// Bench for hbg_top: a vector table of steady states, then directed timing,
// reset, glitch and thermal tests.
module hbg_top_tb;
    localparam int D = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] phase_in = 3'b000;
    logic [2:0] phase_en = 3'b000;
    logic [7:0] temp_code = 8'd25;
    logic [2:0] gate_hi;
    logic [2:0] gate_lo;

    int n_run = 0;
    int n_fail = 0;
    int n_overlap = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hbg_top #(
        .NUM_CH(3), .DEAD_CYC(D), .TEMP_W(8), .TRIP_CODE(160), .RELEASE_CODE(140)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .phase_en(phase_en),
        .temp_code(temp_code), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // Rows: {phase_in, phase_en, expected gate_hi, expected gate_lo}
    localparam logic [11:0] VEC [0:7] = '{
        {3'b111, 3'b111, 3'b111, 3'b000},
        {3'b000, 3'b111, 3'b000, 3'b111},
        {3'b101, 3'b111, 3'b101, 3'b010},
        {3'b010, 3'b011, 3'b010, 3'b001},
        {3'b110, 3'b100, 3'b100, 3'b000},
        {3'b011, 3'b000, 3'b000, 3'b000},
        {3'b001, 3'b110, 3'b000, 3'b110},
        {3'b100, 3'b101, 3'b100, 3'b001}
    };

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Record any cycle where one phase has both gates on (R4).
    always @(negedge clk) begin
        if ((gate_hi & gate_lo) != 3'b000) n_overlap++;
    end

    initial begin
        // R8: reset with enables and inputs already high
        phase_in = 3'b111;
        phase_en = 3'b111;
        step(4);
        chk("R8 hi during reset", gate_hi, 3'b000);
        chk("R8 lo during reset", gate_lo, 3'b000);
        rst_n = 1'b1;
        step(D - 1);
        chk("R8 off through gap after reset", gate_hi, 3'b000);
        step(1);
        chk("R8 on after gap", gate_hi, 3'b111);

        // R1 R2 R3 R11: steady-state table
        for (int i = 0; i < 8; i++) begin
            phase_in = VEC[i][11:9];
            phase_en = VEC[i][8:6];
            step(D + 6);
            chk($sformatf("R2/R3/R1/R11 row %0d hi", i), gate_hi, VEC[i][5:3]);
            chk($sformatf("R2/R3/R1/R11 row %0d lo", i), gate_lo, VEC[i][2:0]);
        end

        // Set all phases high side on
        phase_in = 3'b111;
        phase_en = 3'b111;
        step(D + 6);
        chk("R2 all high", gate_hi, 3'b111);

        // R5 R6 R11: phase 0 hands over high to low
        phase_in = 3'b110;
        step(2);
        chk("R5 still on before third edge", gate_hi, 3'b111);
        step(1);
        chk("R5 off at third edge", gate_hi, 3'b110);
        chk("R5 low not yet on", gate_lo, 3'b000);
        step(D - 1);
        chk("R6 low off at last gap cycle", gate_lo, 3'b000);
        step(1);
        chk("R6 low on after gap", gate_lo, 3'b001);
        chk("R11 other phases unchanged", gate_hi, 3'b110);

        // R7: one-cycle glitch on phase 1 while high side conducts
        phase_in = 3'b100;
        step(1);
        phase_in = 3'b110;
        step(2);
        chk("R7 glitch turns high off", gate_hi, 3'b100);
        begin
            logic [2:0] lo_seen;
            lo_seen = 3'b000;
            for (int c = 0; c < D - 1; c++) begin
                lo_seen = lo_seen | gate_lo;
                step(1);
            end
            lo_seen = lo_seen | gate_lo;
            chk("R7 opposite never on", lo_seen & 3'b010, 3'b000);
            chk("R7 still off at last gap cycle", gate_hi, 3'b100);
        end
        step(1);
        chk("R7 original back on after gap", gate_hi, 3'b110);

        // R1: enable falls on phase 2
        phase_en = 3'b011;
        step(2);
        chk("R1 on before third edge", gate_hi, 3'b110);
        step(1);
        chk("R1 off at third edge", gate_hi, 3'b010);
        phase_en = 3'b111;
        step(D + 6);
        chk("R2 re-enabled", gate_hi, 3'b110);

        // R9: boundary below trip, then trip
        temp_code = 8'd159;
        step(D + 4);
        chk("R9 one below trip no effect", gate_hi, 3'b110);
        temp_code = 8'd160;
        step(1);
        chk("R9 on before second edge", gate_hi, 3'b110);
        step(1);
        chk("R9 all hi off", gate_hi, 3'b000);
        chk("R9 all lo off", gate_lo, 3'b000);

        // R10: hysteresis band keeps gates off
        temp_code = 8'd150;
        step(D + 10);
        chk("R10 off in band 150", gate_hi | gate_lo, 3'b000);
        temp_code = 8'd141;
        step(D + 4);
        chk("R10 off at 141", gate_hi | gate_lo, 3'b000);
        temp_code = 8'd140;
        step(1);
        chk("R10 off before second edge", gate_hi | gate_lo, 3'b000);
        step(1);
        chk("R10 hi resumes", gate_hi, 3'b110);
        chk("R10 lo resumes", gate_lo, 3'b001);

        chk("R4 no overlap seen", (n_overlap != 0) ? 3'b001 : 3'b000, 3'b000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule